// File: doc/BRIEF.md
# HDLC Transmit Buffer Controller

This block is the transmit-side byte buffer between a host bus and an HDLC frame transmitter. The host writes frame bytes into a 64-byte store in blocks of 16 or 32. After each block it issues a command: "send" releases the block as part of a frame that is still open, and "end" releases it and closes the frame. Bytes reach the transmitter only after such a command. The store can hold several whole frames at once. Each byte leaves with a last-byte marker, so the transmitter can close the frame.

The controller raises three events, each cleared by a status read: a pool-ready event when another block fits, an underrun event when the transmitter starves in the middle of a frame, and a repeat event when the channel is lost after a frame's first block has already gone out. If the channel is lost earlier than that, the controller rewinds and replays the frame from its first byte. Underrun and repeat both flush the store and lock out host writes until the status is read. Writing past the block size, or into a full store, sets a sticky overflow flag that only the reset command clears.

Both data paths are valid/ready streams. The host side never applies back-pressure: `host_ready` is tied high, and the controller drops any byte that the rules below reject. On the transmitter side, a byte moves on every cycle in which `tx_valid` and `tx_ready` are both high. `tx_valid` may fall without a transfer if the channel is lost or the store is flushed.

Top module: `hdlc_txbuf`

## Requirements
- R1: The store holds 64 bytes, which may belong to several frames. Bytes leave in the order they were written. A written byte stays invisible to the transmitter (`tx_valid` low) until a send or end command is issued, and the command is visible on the cycle after it.
- R2: The end command sets `tx_last` on the last byte written before it. It sets `tx_last` on no other byte.
- R3: A host write is dropped and `st_overflow` is set in either of two cases: the bytes written since the last command already equal the active block size, or the store holds 64 bytes. Once `st_overflow` is set it stays set, and every later write is dropped.
- R4: The active block size is 16 when `cfg_long_blk` is 0 and 32 when it is 1. It is sampled only when a send, end or reset command is accepted. The value out of reset is 16.
- R5: The reset command empties the store, which drops `tx_valid` on the next cycle. It clears `st_overflow` and re-arms the pool-ready event.
- R6: A frame is open once it has sent at least one byte. If `tx_ready` is high while a frame is open and the store is empty, `ev_underrun` is set and the store is flushed.
- R7: A `chan_lost` pulse that arrives while a frame is open, before a full block of that frame has been sent, rewinds the output. The frame is then replayed from its first byte.
- R8: A `chan_lost` pulse that arrives once an open frame has sent at least one full block sets `ev_repeat` and flushes the store.
- R9: While `ev_underrun` or `ev_repeat` is set, host writes, send commands and end commands are ignored. `stat_read` clears both events and lifts the lock.
- R10: `ev_pool_ready` is set once per arming, at a point where the free space is at least one block and the lock is off. Reset, every accepted command and every flush arm it. `stat_read` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Host byte present |
| host_data | input | 8 | Host byte |
| host_ready | output | 1 | Always high; rejected bytes are dropped |
| cmd_send | input | 1 | Release the written block, frame stays open |
| cmd_end | input | 1 | Release the written block and close the frame |
| cmd_reset | input | 1 | Flush the store and clear overflow |
| cfg_long_blk | input | 1 | Block size select: 0 = 16, 1 = 32 |
| stat_read | input | 1 | Status read pulse, clears events |
| chan_lost | input | 1 | Channel lost pulse from the transmitter |
| tx_valid | output | 1 | Byte available for the transmitter |
| tx_ready | input | 1 | Transmitter takes / needs a byte |
| tx_data | output | 8 | Byte to transmit |
| tx_last | output | 1 | Byte closes its frame |
| ev_pool_ready | output | 1 | Room for another block |
| ev_underrun | output | 1 | Transmitter starved mid-frame |
| ev_repeat | output | 1 | Frame must be resent by the host |
| st_overflow | output | 1 | Sticky block-size or capacity violation |

## Verification
A wrong pointer or a wrong anchor shows up at the ports as a wrong byte, or as a misplaced `tx_last`, at the next transfer. It also shows up as a pool-ready event at the wrong fill level. A wrong frame-progress count shows up on the first `chan_lost`, which either replays from a wrong byte or raises the repeat event when a replay was due, or the reverse. A wrong lock or overflow state shows up on the next host write, as a byte that appears or vanishes after the following command.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic int cnt_width(input int max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/txbuf_store.sv
module txbuf_store
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  byte_t         wdata,
  input  logic          wlast,
  input  logic          mark,
  input  logic [AW-1:0] maddr,
  input  logic [AW-1:0] raddr,
  output byte_t         rdata,
  output logic          rlast
);
  byte_t mem_d [DEPTH];
  logic  mem_l [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_d[waddr] <= wdata;
      mem_l[waddr] <= wlast;
    end
    if (mark) mem_l[maddr] <= 1'b1;
  end

  assign rdata = mem_d[raddr];
  assign rlast = mem_l[raddr];
endmodule

// File: rtl/txbuf_wr.sv
module txbuf_wr
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BLK_S = 16,
  parameter int BLK_L = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = cnt_width(BLK_L)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_valid,
  input  byte_t         host_data,
  input  logic          cmd_send,
  input  logic          cmd_end,
  input  logic          cmd_reset,
  input  logic          cfg_long_blk,
  input  logic          locked,
  input  logic          flush,
  input  logic [PW-1:0] anchor,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] cm_ptr,
  output logic [CW-1:0] blk_act,
  output logic          st_ovf,
  output logic          cmd_ok,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output byte_t         mem_wdata,
  output logic          mem_wlast,
  output logic          mem_mark,
  output logic [AW-1:0] mem_maddr
);
  logic [CW-1:0] wcnt;
  logic [PW-1:0] occ;
  logic          full, wr_try, wr_over, wr_acc, rel_cmd;
  logic [CW-1:0] blk_sel;

  assign occ     = wr_ptr - anchor;
  assign full    = (occ == PW'(DEPTH));
  assign wr_try  = host_valid && !locked && !st_ovf;
  assign wr_over = wr_try && ((wcnt == blk_act) || full);
  assign wr_acc  = wr_try && !wr_over;
  assign rel_cmd = (cmd_send || cmd_end) && !locked;
  assign blk_sel = cfg_long_blk ? CW'(BLK_L) : CW'(BLK_S);
  assign cmd_ok  = rel_cmd || cmd_reset;

  assign mem_we    = wr_acc && !flush;
  assign mem_waddr = wr_ptr[AW-1:0];
  assign mem_wdata = host_data;
  assign mem_wlast = rel_cmd && cmd_end;
  assign mem_mark  = rel_cmd && cmd_end && !wr_acc && (wr_ptr != cm_ptr) && !flush;
  assign mem_maddr = AW'(wr_ptr - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      cm_ptr  <= '0;
      wcnt    <= '0;
      st_ovf  <= 1'b0;
      blk_act <= CW'(BLK_S);
    end else if (flush) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
      wcnt   <= '0;
      if (cmd_reset) begin
        st_ovf  <= 1'b0;
        blk_act <= blk_sel;
      end
    end else begin
      if (wr_acc) begin
        wr_ptr <= wr_ptr + PW'(1);
        wcnt   <= wcnt + CW'(1);
      end
      if (wr_over) st_ovf <= 1'b1;
      if (rel_cmd) begin
        cm_ptr  <= wr_ptr + PW'(wr_acc);
        wcnt    <= '0;
        blk_act <= blk_sel;
      end
    end
  end

  // R9: a locked write leaves the write pointer alone
  p_lock_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !cmd_reset) |=> $stable(wr_ptr));
  // R3: overflow is sticky until the reset command
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovf && !cmd_reset) |=> st_ovf);
  // R3: never more bytes per block than the active size
  p_wcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= blk_act);
  // R4: only the two legal sizes
  p_blk_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_act == CW'(BLK_S)) || (blk_act == CW'(BLK_L)));
  // R1: occupancy never exceeds the store
  p_occ_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PW'(DEPTH));
endmodule

// File: rtl/txbuf_rd.sv
module txbuf_rd
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BLK_L = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = cnt_width(BLK_L)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          locked,
  input  logic [PW-1:0] cm_ptr,
  input  logic [CW-1:0] blk_act,
  input  logic          tx_ready,
  input  logic          chan_lost,
  input  logic          byte_last,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] anchor,
  output logic          tx_valid,
  output logic          xdu_evt,
  output logic          xmr_evt
);
  logic [CW-1:0] sent;
  logic          in_frame, pop, retry, have_data;
  logic [CW-1:0] sent_nx;

  assign have_data = (rd_ptr != cm_ptr);
  assign in_frame  = (sent != '0);
  assign tx_valid  = have_data && !chan_lost && !locked;
  assign pop       = tx_valid && tx_ready;
  assign xdu_evt   = !locked && in_frame && tx_ready && !have_data && !chan_lost;
  assign xmr_evt   = !locked && chan_lost && in_frame && (sent >= blk_act);
  assign retry     = !locked && chan_lost && in_frame && (sent < blk_act);
  assign sent_nx   = sent + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      anchor <= '0;
      sent   <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      anchor <= '0;
      sent   <= '0;
    end else if (retry) begin
      rd_ptr <= anchor;
      sent   <= '0;
    end else if (pop) begin
      rd_ptr <= rd_ptr + PW'(1);
      if (byte_last) begin
        anchor <= rd_ptr + PW'(1);
        sent   <= '0;
      end else if (sent_nx >= blk_act) begin
        anchor <= rd_ptr + PW'(1);
        sent   <= blk_act;
      end else begin
        sent <= sent_nx;
      end
    end
  end

  // R7: the replay anchor never trails the output by more than one block
  p_anchor_near_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr - anchor) <= PW'(blk_act));
  // R8: a repeat event and a replay never coincide
  p_repeat_or_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(xmr_evt && retry));
endmodule

// File: rtl/txbuf_irq.sv
module txbuf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic xdu_evt,
  input  logic xmr_evt,
  input  logic arm_evt,
  input  logic room_ok,
  input  logic stat_read,
  output logic ev_pool_ready,
  output logic ev_underrun,
  output logic ev_repeat,
  output logic locked
);
  logic armed;

  assign locked = ev_underrun || ev_repeat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed         <= 1'b1;
      ev_pool_ready <= 1'b0;
      ev_underrun   <= 1'b0;
      ev_repeat     <= 1'b0;
    end else begin
      if (stat_read) begin
        ev_pool_ready <= 1'b0;
        ev_underrun   <= 1'b0;
        ev_repeat     <= 1'b0;
      end
      if (xdu_evt) ev_underrun <= 1'b1;
      if (xmr_evt) ev_repeat <= 1'b1;
      if (arm_evt) armed <= 1'b1;
      else if (armed && room_ok && !locked) begin
        armed         <= 1'b0;
        ev_pool_ready <= 1'b1;
      end
    end
  end

  // R9: the lock persists until a status read
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !stat_read) |=> locked);
  // R10: pool-ready only rises with room and no lock
  p_pool_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_pool_ready) |-> ($past(room_ok) && !$past(locked)));
endmodule

// File: rtl/hdlc_txbuf.sv
module hdlc_txbuf
  import txbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BLK_S = 16,
  parameter int BLK_L = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = cnt_width(BLK_L)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_valid,
  input  logic [7:0] host_data,
  output logic       host_ready,
  input  logic       cmd_send,
  input  logic       cmd_end,
  input  logic       cmd_reset,
  input  logic       cfg_long_blk,
  input  logic       stat_read,
  input  logic       chan_lost,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_last,
  output logic       ev_pool_ready,
  output logic       ev_underrun,
  output logic       ev_repeat,
  output logic       st_overflow
);
  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr, anchor, free_sp;
  logic [CW-1:0] blk_act;
  logic          locked, flush, cmd_ok, xdu_evt, xmr_evt, room_ok;
  logic          m_we, m_wlast, m_mark;
  logic [AW-1:0] m_waddr, m_maddr;
  byte_t         m_wdata;

  assign host_ready = 1'b1;
  assign flush      = xdu_evt || xmr_evt || cmd_reset;
  assign free_sp    = PW'(DEPTH) - (wr_ptr - anchor);
  assign room_ok    = free_sp >= PW'(blk_act);

  txbuf_wr #(.DEPTH(DEPTH), .BLK_S(BLK_S), .BLK_L(BLK_L)) u_wr (
    .clk, .rst_n, .host_valid, .host_data, .cmd_send, .cmd_end, .cmd_reset,
    .cfg_long_blk, .locked, .flush, .anchor, .wr_ptr, .cm_ptr, .blk_act,
    .st_ovf(st_overflow), .cmd_ok, .mem_we(m_we), .mem_waddr(m_waddr),
    .mem_wdata(m_wdata), .mem_wlast(m_wlast), .mem_mark(m_mark),
    .mem_maddr(m_maddr)
  );

  txbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk, .we(m_we), .waddr(m_waddr), .wdata(m_wdata), .wlast(m_wlast),
    .mark(m_mark), .maddr(m_maddr), .raddr(rd_ptr[AW-1:0]),
    .rdata(tx_data), .rlast(tx_last)
  );

  txbuf_rd #(.DEPTH(DEPTH), .BLK_L(BLK_L)) u_rd (
    .clk, .rst_n, .flush, .locked, .cm_ptr, .blk_act, .tx_ready, .chan_lost,
    .byte_last(tx_last), .rd_ptr, .anchor, .tx_valid, .xdu_evt, .xmr_evt
  );

  txbuf_irq u_irq (
    .clk, .rst_n, .xdu_evt, .xmr_evt, .arm_evt(cmd_ok || flush), .room_ok,
    .stat_read, .ev_pool_ready, .ev_underrun, .ev_repeat, .locked
  );

  // R6: an underrun leaves nothing for the transmitter
  p_underrun_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_underrun) |-> !tx_valid);
  // R5: after the reset command the store is empty
  p_reset_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> !tx_valid);
  // R1: the output pointer never passes the committed pointer
  p_rd_behind_cm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_ptr - rd_ptr) <= PW'(DEPTH));
endmodule

// File: tb/tb_hdlc_txbuf.sv
module tb_hdlc_txbuf;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_valid = 0, cmd_send = 0, cmd_end = 0, cmd_reset = 0;
  logic cfg_long_blk = 0, stat_read = 0, chan_lost = 0, tx_ready = 0;
  logic [7:0] host_data = '0, tx_data;
  logic host_ready, tx_valid, tx_last, ev_pool_ready, ev_underrun, ev_repeat, st_overflow;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  hdlc_txbuf dut (.*);

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); host_valid = 1; host_data = 8'(base + i);
    end
    @(negedge clk); host_valid = 0;
  endtask

  task automatic issue(input int which);
    @(negedge clk);
    cmd_send = (which == 0); cmd_end = (which == 1); cmd_reset = (which == 2);
    @(negedge clk);
    cmd_send = 0; cmd_end = 0; cmd_reset = 0;
  endtask

  task automatic rd_status();
    @(negedge clk); stat_read = 1;
    @(negedge clk); stat_read = 0;
  endtask

  task automatic lose_chan();
    @(negedge clk); chan_lost = 1;
    @(negedge clk); chan_lost = 0;
  endtask

  task automatic pop_expect(input string req, input int n, input int base, input int last_i);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_ready = 1; #1;
      check({req, " valid"}, int'(tx_valid), 1);
      check({req, " data"}, int'(tx_data), (base + i) & 255);
      check({req, " last"}, int'(tx_last), int'(i == last_i));
    end
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic t_reset();
    check("R5 reset valid", int'(tx_valid), 0);
    check("R6 reset underrun", int'(ev_underrun), 0);
    check("R8 reset repeat", int'(ev_repeat), 0);
    check("R3 reset overflow", int'(st_overflow), 0);
    check("R1 host_ready", int'(host_ready), 1);
    repeat (2) @(negedge clk);
    check("R10 pool after reset", int'(ev_pool_ready), 1);
    rd_status();
    check("R10 pool cleared", int'(ev_pool_ready), 0);
  endtask

  task automatic t_frames();
    put_bytes(5, 8'h10);
    check("R1 hidden before command", int'(tx_valid), 0);
    issue(1);
    check("R1 visible after end", int'(tx_valid), 1);
    pop_expect("R2 frame", 5, 8'h10, 4);
    put_bytes(3, 8'h20); issue(1);
    put_bytes(2, 8'h30); issue(1);
    pop_expect("R1 first of two", 3, 8'h20, 2);
    pop_expect("R1 second of two", 2, 8'h30, 1);
    check("R1 drained", int'(tx_valid), 0);
  endtask

  task automatic t_overflow();
    put_bytes(17, 8'h40);
    check("R3 overflow set", int'(st_overflow), 1);
    issue(0);
    check("R3 sticky over command", int'(st_overflow), 1);
    pop_expect("R3 kept 16", 16, 8'h40, -1);
    check("R3 17th dropped", int'(tx_valid), 0);
    put_bytes(1, 8'h55); issue(0);
    check("R3 later write dropped", int'(tx_valid), 0);
    issue(2);
    check("R5 reset clears overflow", int'(st_overflow), 0);
  endtask

  task automatic t_blksize();
    cfg_long_blk = 1;
    put_bytes(17, 0);
    check("R4 still 16 until command", int'(st_overflow), 1);
    issue(2);
    put_bytes(32, 0);
    check("R4 32 accepted", int'(st_overflow), 0);
    put_bytes(1, 0);
    check("R4 33rd overflows", int'(st_overflow), 1);
    cfg_long_blk = 0;
    issue(2);
    check("R4 reset clears", int'(st_overflow), 0);
  endtask

  task automatic t_reset_cmd();
    put_bytes(6, 8'h70); issue(0);
    check("R5 data present", int'(tx_valid), 1);
    rd_status();
    issue(2);
    check("R5 flushed", int'(tx_valid), 0);
    @(negedge clk);
    check("R5 pool rearmed", int'(ev_pool_ready), 1);
    rd_status();
  endtask

  task automatic t_underrun();
    put_bytes(4, 8'h90); issue(0);
    rd_status();
    @(negedge clk); tx_ready = 1;
    repeat (5) @(negedge clk);
    tx_ready = 0;
    check("R6 underrun raised", int'(ev_underrun), 1);
    check("R6 store flushed", int'(tx_valid), 0);
    put_bytes(2, 8'h99); issue(1);
    check("R9 write locked", int'(tx_valid), 0);
    check("R10 no pool while locked", int'(ev_pool_ready), 0);
    rd_status();
    check("R9 read clears underrun", int'(ev_underrun), 0);
    @(negedge clk);
    check("R10 pool after unlock", int'(ev_pool_ready), 1);
    put_bytes(2, 8'hA0); issue(1);
    pop_expect("R9 writes resume", 2, 8'hA0, 1);
  endtask

  task automatic t_retry();
    put_bytes(10, 8'h60); issue(1);
    pop_expect("R7 before loss", 3, 8'h60, -1);
    lose_chan();
    check("R7 no repeat event", int'(ev_repeat), 0);
    pop_expect("R7 replay", 10, 8'h60, 9);
  endtask

  task automatic t_repeat();
    put_bytes(16, 8'h80); issue(0);
    pop_expect("R8 first block", 16, 8'h80, -1);
    lose_chan();
    check("R8 repeat raised", int'(ev_repeat), 1);
    check("R8 store flushed", int'(tx_valid), 0);
    put_bytes(1, 8'h11); issue(0);
    check("R9 locked by repeat", int'(tx_valid), 0);
    rd_status();
    check("R9 read clears repeat", int'(ev_repeat), 0);
  endtask

  task automatic t_pool();
    issue(2);
    for (int k = 0; k < 4; k++) begin
      put_bytes(16, 16 * k); issue(0);
    end
    check("R1 64 bytes no overflow", int'(st_overflow), 0);
    repeat (2) @(negedge clk);
    rd_status();
    repeat (2) @(negedge clk);
    check("R10 no pool when full", int'(ev_pool_ready), 0);
    put_bytes(1, 8'hEE);
    check("R3 full store overflows", int'(st_overflow), 1);
    pop_expect("R1 full drain", 16, 0, -1);
    @(negedge clk);
    check("R10 pool after a block frees", int'(ev_pool_ready), 1);
    issue(2);
    rd_status();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_frames();
    t_overflow();
    t_blksize();
    t_reset_cmd();
    t_underrun();
    t_retry();
    t_repeat();
    t_pool();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule